// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small fully associative cache of page translations that sits between a requester and the in-memory page table. A lookup request carries a virtual address and a read/write flag. The upper bits of the address select a virtual page and the lower bits give the byte offset within that page. The page number is compared against every stored entry in the same cycle. A hit returns the physical address, formed from the stored frame number and the unchanged offset, together with the entry's modified flag. When no entry matches, the block reports a miss. An entry whose permissions forbid the access raises a protection fault in place of the translation.

Missed pages are supplied through a refill port. The entry written on refill is chosen in this order: the slot that already holds the same page, then the lowest free slot, then the least recently used slot. A write hit that is allowed marks its entry modified. A synchronous flush invalidates every entry, so that software can keep the buffer consistent with the page table in memory. The page size, the address widths and the entry count are parameters. The defaults are 4 KB pages, 32-bit virtual and physical addresses and 8 entries.

Top module: `xlat_buf`

## Requirements
- R1: The virtual page number is `req_vaddr_i[VA_W-1:OFF_W]` and the offset is `req_vaddr_i[OFF_W-1:0]`, with OFF_W = log2(PAGE_BYTES). PAGE_BYTES is a power of two from 2048 to 16384. The defaults are PAGE_BYTES 4096 and VA_W = PA_W = 32.
- R2: A lookup whose page matches a valid, present entry that permits the access sets `resp_hit_o` in the same cycle. It drives `resp_paddr_o = {frame, offset}` and puts the entry's modified flag on `resp_dirty_o`.
- R3: A lookup that matches no valid, present entry sets `resp_miss_o`, with `resp_hit_o` and `resp_fault_o` low.
- R4: An entry whose present flag is clear never produces a hit; a lookup of its page reports a miss.
- R5: A read lookup of a matching entry with read permission 0, or a write lookup of one with write permission 0, sets `resp_fault_o` with hit and miss low. It leaves the modified flag of the entry unchanged.
- R6: A write hit sets the modified flag of the entry at the next clock edge. Later hits on that entry report `resp_dirty_o = 1`.
- R7: `fill_valid_i` writes an entry at the clock edge. The slot is chosen as follows: the valid slot holding `fill_vpn_i` (its present flag is ignored) if there is one, otherwise the lowest-numbered invalid slot, otherwise the least recently used slot.
- R8: Recency is refreshed only by a hit and by a refill. Misses and faults leave the replacement order unchanged.
- R9: `flush_i` invalidates all entries at the next edge. A refill requested in the same cycle is dropped.
- R10: After reset, every entry is invalid.
- R11: While `req_valid_i` is low, `resp_hit_o`, `resp_miss_o`, `resp_fault_o`, `resp_dirty_o` and `resp_paddr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request present |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| resp_hit_o | output | 1 | Translation valid |
| resp_miss_o | output | 1 | No entry for the page |
| resp_fault_o | output | 1 | Matching entry forbids the access |
| resp_dirty_o | output | 1 | Modified flag of the hit entry |
| resp_paddr_o | output | PA_W | Translated physical address |
| fill_valid_i | input | 1 | Refill an entry |
| fill_vpn_i | input | VA_W-OFF_W | Page number of the refill |
| fill_pfn_i | input | PA_W-OFF_W | Frame number of the refill |
| fill_present_i | input | 1 | Present flag of the refill |
| fill_dirty_i | input | 1 | Initial modified flag of the refill |
| fill_rd_i | input | 1 | Read permission of the refill |
| fill_wr_i | input | 1 | Write permission of the refill |

## Verification
Lookups are run against several kinds of entries:
- Cold misses, checked against a buffer freshly reset or flushed, show that no stale entry survives.
- Entries with each permission combination separate the fault path from the hit path.
- An entry filled with its present flag clear, and later refilled with it set, separates presence from validity and also proves that a refill overwrites the slot holding the same page.
- The buffer is filled to capacity and then touched in a chosen order, so the page that goes missing after each refill shows which victim was picked.
- A faulting access placed just before a refill shows that faults do not refresh recency.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Per-entry control flags held next to each translation
  typedef struct packed {
    logic present;
    logic dirty;
    logic rd;
    logic wr;
  } pte_flags_t;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N             = 8,
  parameter int KEY_W         = 20,
  parameter bit CHECK_PRESENT = 1'b1,
  localparam int IDX_W        = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] tag_i [N],
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     present_i,
  output logic [N-1:0]     match_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    if (CHECK_PRESENT) begin : g_pres
      assign match_o[i] = valid_i[i] & present_i[i] & (tag_i[i] == key_i);
    end else begin : g_nopres
      assign match_o[i] = valid_i[i] & (tag_i[i] == key_i);
    end
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  // R2: the table never holds two live copies of one page
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_o));
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N      = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_d [N];
  logic [N-1:0]     is_oldest;

  // Ages form a permutation; a touched slot becomes 0, younger ones age by one
  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (touch_i) begin
        if (IDX_W'(i) == touch_idx_i)
          age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx_i])
          age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_old
    assign is_oldest[i] = (age_q[i] == OLDEST);
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (is_oldest[i]) victim_o = IDX_W'(i);
    end
  end

  // R8: exactly one slot is the least recently used at all times
  a_r8_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int ENTRIES    = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PFN_W     = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             resp_hit_o,
  output logic             resp_miss_o,
  output logic             resp_fault_o,
  output logic             resp_dirty_o,
  output logic [PA_W-1:0]  resp_paddr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_present_i,
  input  logic             fill_dirty_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i
);
  import xlat_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  logic rst_q_n;

  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  pte_flags_t         flg_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;

  logic [ENTRIES-1:0] present_v, dirty_v;
  logic [ENTRIES-1:0] look_match, fill_match;
  logic               look_any, fill_any;
  logic [IDX_W-1:0]   look_idx, fill_idx;
  logic [IDX_W-1:0]   victim_idx, free_idx, fill_slot;
  logic               free_any;

  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  pte_flags_t         sel_flg;
  logic               perm_ok;

  logic               fill_en, dirty_en;
  logic               lru_touch;
  logic [IDX_W-1:0]   lru_idx;

  xlat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off = req_vaddr_i[OFF_W-1:0];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flags
    assign present_v[i] = flg_q[i].present;
    assign dirty_v[i]   = flg_q[i].dirty;
  end

  // Lookup compare: only present entries may hit
  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W), .CHECK_PRESENT(1'b1)) u_look_cam (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .key_i     (req_vpn),
    .tag_i     (vpn_q),
    .valid_i   (valid_q),
    .present_i (present_v),
    .match_o   (look_match),
    .any_o     (look_any),
    .idx_o     (look_idx)
  );

  // Refill compare: any valid copy of the page is overwritten in place
  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W), .CHECK_PRESENT(1'b0)) u_fill_cam (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .key_i     (fill_vpn_i),
    .tag_i     (vpn_q),
    .valid_i   (valid_q),
    .present_i (present_v),
    .match_o   (fill_match),
    .any_o     (fill_any),
    .idx_o     (fill_idx)
  );

  xlat_lru #(.N(ENTRIES)) u_lru (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .touch_i     (lru_touch),
    .touch_idx_i (lru_idx),
    .victim_o    (victim_idx)
  );

  // Response path
  always_comb begin
    sel_flg = flg_q[look_idx];
    perm_ok = req_write_i ? sel_flg.wr : sel_flg.rd;
    resp_hit_o   = req_valid_i & look_any & perm_ok;
    resp_fault_o = req_valid_i & look_any & ~perm_ok;
    resp_miss_o  = req_valid_i & ~look_any;
    resp_dirty_o = resp_hit_o & sel_flg.dirty;
    resp_paddr_o = resp_hit_o ? {pfn_q[look_idx], req_off} : '0;
  end

  // Lowest free slot
  always_comb begin
    free_any = ~&valid_q;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  // Control: flush beats refill; refill beats the dirty update on one slot
  always_comb begin
    fill_slot = fill_any ? fill_idx : (free_any ? free_idx : victim_idx);
    fill_en   = fill_valid_i & ~flush_i;
    dirty_en  = resp_hit_o & req_write_i & ~flush_i &
                ~(fill_en && (fill_slot == look_idx));
    lru_touch = ~flush_i & (fill_valid_i | resp_hit_o);
    lru_idx   = fill_valid_i ? fill_slot : look_idx;

    valid_d = valid_q;
    if (flush_i)      valid_d = '0;
    else if (fill_en) valid_d[fill_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) valid_q <= '0;
    else          valid_q <= valid_d;
  end

  // Entry payload: enabled writes, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[fill_slot] <= fill_vpn_i;
      pfn_q[fill_slot] <= fill_pfn_i;
      flg_q[fill_slot] <= '{present: fill_present_i, dirty: fill_dirty_i,
                            rd: fill_rd_i, wr: fill_wr_i};
    end
    if (dirty_en) flg_q[look_idx].dirty <= 1'b1;
  end

  // R3: an unmatched request is always reported as a miss
  a_r3_nomatch_is_miss: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid_i && !look_any) |-> (resp_miss_o && !resp_hit_o && !resp_fault_o));

  // R4: a hit only comes from an entry flagged present
  a_r4_hit_needs_present: assert property (@(posedge clk) disable iff (!rst_q_n)
    resp_hit_o |-> ((look_match & present_v) != '0));

  // R5: a faulting access does not mark anything modified
  a_r5_fault_keeps_dirty: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_fault_o && !fill_valid_i && !flush_i) |=> $stable(dirty_v));

  // R6: an allowed write leaves its entry modified
  a_r6_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_hit_o && req_write_i && !flush_i && !fill_valid_i)
      |=> ((dirty_v & $past(look_match)) != '0));

  // R9: flush empties the table at the next edge
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_q_n)
    flush_i |=> (valid_q == '0));

  // R11: idle request gives quiet outputs
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid_i |-> !(resp_hit_o || resp_miss_o || resp_fault_o || resp_dirty_o));
endmodule

// File: tb/xlat_buf_tb.sv
module xlat_buf_tb_top;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic flush_i, req_valid_i, req_write_i;
  logic [VA_W-1:0] req_vaddr_i;
  logic resp_hit_o, resp_miss_o, resp_fault_o, resp_dirty_o;
  logic [PA_W-1:0] resp_paddr_o;
  logic fill_valid_i, fill_present_i, fill_dirty_i, fill_rd_i, fill_wr_i;
  logic [VPN_W-1:0] fill_vpn_i;
  logic [PFN_W-1:0] fill_pfn_i;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xlat_buf dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_vaddr_i(req_vaddr_i),
    .resp_hit_o(resp_hit_o), .resp_miss_o(resp_miss_o), .resp_fault_o(resp_fault_o),
    .resp_dirty_o(resp_dirty_o), .resp_paddr_o(resp_paddr_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_present_i(fill_present_i), .fill_dirty_i(fill_dirty_i),
    .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i)
  );

  function automatic logic [PFN_W-1:0] frame_of(input logic [VPN_W-1:0] v);
    return v ^ 20'hA5000;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] f,
                      input logic p, input logic d, input logic r, input logic w);
    @(negedge clk);
    fill_valid_i = 1'b1; fill_vpn_i = v; fill_pfn_i = f;
    fill_present_i = p; fill_dirty_i = d; fill_rd_i = r; fill_wr_i = w;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  // kind: 0 hit, 1 miss, 2 fault
  task automatic look(input string tag, input logic wr, input logic [VPN_W-1:0] v,
                      input logic [OFF_W-1:0] off, input int kind,
                      input logic [PFN_W-1:0] f, input logic d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_vaddr_i = {v, off};
    #1;
    check({tag, " hit"},   64'(resp_hit_o),   64'(kind == 0));
    check({tag, " miss"},  64'(resp_miss_o),  64'(kind == 1));
    check({tag, " fault"}, 64'(resp_fault_o), 64'(kind == 2));
    if (kind == 0) begin
      check({tag, " paddr"}, 64'(resp_paddr_o), 64'({f, off}));
      check({tag, " dirty"}, 64'(resp_dirty_o), 64'(d));
    end
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic do_flush(input logic with_fill, input logic [VPN_W-1:0] v);
    @(negedge clk);
    flush_i = 1'b1;
    if (with_fill) begin
      fill_valid_i = 1'b1; fill_vpn_i = v; fill_pfn_i = frame_of(v);
      fill_present_i = 1'b1; fill_dirty_i = 1'b0; fill_rd_i = 1'b1; fill_wr_i = 1'b1;
    end
    @(negedge clk);
    flush_i = 1'b0; fill_valid_i = 1'b0;
  endtask

  task automatic t_reset_idle();
    #1;
    check("R11 idle hit",   64'(resp_hit_o),   64'd0);
    check("R11 idle miss",  64'(resp_miss_o),  64'd0);
    check("R11 idle paddr", 64'(resp_paddr_o), 64'd0);
    look("R10 cold lookup", 1'b0, 20'h12345, 12'h678, 1, '0, 1'b0);
  endtask

  task automatic t_hit_dirty();
    fill(20'h12345, 20'hABCDE, 1'b1, 1'b0, 1'b1, 1'b1);
    look("R1 R2 read hit",   1'b0, 20'h12345, 12'h678, 0, 20'hABCDE, 1'b0);
    look("R2 write hit",     1'b1, 20'h12345, 12'hFFF, 0, 20'hABCDE, 1'b0);
    look("R6 dirty after write", 1'b0, 20'h12345, 12'h000, 0, 20'hABCDE, 1'b1);
  endtask

  task automatic t_perm();
    fill(20'h00001, 20'h00111, 1'b1, 1'b0, 1'b1, 1'b0);
    look("R5 write no perm", 1'b1, 20'h00001, 12'h004, 2, '0, 1'b0);
    look("R5 dirty untouched", 1'b0, 20'h00001, 12'h004, 0, 20'h00111, 1'b0);
    fill(20'h00002, 20'h00222, 1'b1, 1'b0, 1'b0, 1'b1);
    look("R5 read no perm",  1'b0, 20'h00002, 12'h010, 2, '0, 1'b0);
    look("R5 write allowed", 1'b1, 20'h00002, 12'h010, 0, 20'h00222, 1'b0);
  endtask

  task automatic t_present();
    fill(20'h00003, 20'h00333, 1'b0, 1'b0, 1'b1, 1'b1);
    look("R4 absent page misses", 1'b0, 20'h00003, 12'h020, 1, '0, 1'b0);
    fill(20'h00003, 20'h00444, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R7 refill same page", 1'b0, 20'h00003, 12'h020, 0, 20'h00444, 1'b1);
  endtask

  task automatic t_flush();
    do_flush(1'b0, '0);
    look("R9 flushed page A", 1'b0, 20'h12345, 12'h678, 1, '0, 1'b0);
    look("R9 flushed page B", 1'b0, 20'h00001, 12'h004, 1, '0, 1'b0);
    do_flush(1'b1, 20'h00009);
    look("R9 fill dropped by flush", 1'b0, 20'h00009, 12'h000, 1, '0, 1'b0);
  endtask

  task automatic t_lru();
    do_flush(1'b0, '0);
    for (int i = 0; i < 8; i++) fill(20'h10 + 20'(i), frame_of(20'h10 + 20'(i)), 1'b1, 1'b0, 1'b1, 1'b1);
    look("R7 slot0 hit", 1'b0, 20'h10, 12'h0AB, 0, frame_of(20'h10), 1'b0);
    fill(20'h20, frame_of(20'h20), 1'b1, 1'b0, 1'b1, 1'b1);
    look("R8 LRU evicted", 1'b0, 20'h11, 12'h0AB, 1, '0, 1'b0);
    look("R8 touched kept", 1'b0, 20'h10, 12'h0AB, 0, frame_of(20'h10), 1'b0);
    look("R7 new page hit", 1'b0, 20'h20, 12'h0AB, 0, frame_of(20'h20), 1'b0);
    fill(20'h21, frame_of(20'h21), 1'b1, 1'b0, 1'b1, 1'b1);
    look("R8 next LRU evicted", 1'b0, 20'h12, 12'h0AB, 1, '0, 1'b0);
    fill(20'h13, 20'h77777, 1'b1, 1'b0, 1'b1, 1'b1);
    look("R7 overwrite in place", 1'b0, 20'h13, 12'h0AB, 0, 20'h77777, 1'b0);
    for (int i = 4; i < 8; i++)
      look("R7 no eviction on overwrite", 1'b0, 20'h10 + 20'(i), 12'h0AB, 0, frame_of(20'h10 + 20'(i)), 1'b0);
    look("R7 keep 10", 1'b0, 20'h10, 12'h0AB, 0, frame_of(20'h10), 1'b0);
    look("R7 keep 20", 1'b0, 20'h20, 12'h0AB, 0, frame_of(20'h20), 1'b0);
    look("R7 keep 21", 1'b0, 20'h21, 12'h0AB, 0, frame_of(20'h21), 1'b0);
  endtask

  task automatic t_fault_no_touch();
    do_flush(1'b0, '0);
    fill(20'h30, frame_of(20'h30), 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 1; i < 8; i++) fill(20'h30 + 20'(i), frame_of(20'h30 + 20'(i)), 1'b1, 1'b0, 1'b1, 1'b1);
    look("R8 fault on oldest", 1'b1, 20'h30, 12'h001, 2, '0, 1'b0);
    fill(20'h40, frame_of(20'h40), 1'b1, 1'b0, 1'b1, 1'b1);
    look("R8 fault did not refresh", 1'b0, 20'h30, 12'h001, 1, '0, 1'b0);
    look("R8 second oldest kept", 1'b0, 20'h31, 12'h001, 0, frame_of(20'h31), 1'b0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
    req_vaddr_i = '0; fill_valid_i = 1'b0; fill_vpn_i = '0; fill_pfn_i = '0;
    fill_present_i = 1'b0; fill_dirty_i = 1'b0; fill_rd_i = 1'b0; fill_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_idle();
    t_hit_dirty();
    t_perm();
    t_present();
    t_flush();
    t_lru();
    t_fault_no_touch();
    summary();
    $finish;
  end
endmodule